// File: doc/BRIEF.md
# Key-Locked Reset Watchdog

This block is a countdown watchdog driven by a slow 32.768 kHz tick. Software programs a 32-bit timeout as two 16-bit halves, sets a run bit to start the countdown, and may set a reset-enable bit. When the count reaches zero with reset enabled, the block raises a system reset request. That request stays high until the block itself is reset.

A lock register guards the timeout halves and the control register. Writes to these registers take effect only after the 16-bit key 0xE551 has been written to the lock register. Any other value written there locks the block again, for example the key's complement 0x1AAE. Reads are always allowed. At 32768 ticks per second, a 50 ms timeout is a load value of 1638.

The register bus is a plain single-cycle interface. A write is taken on the clock edge where the write strobe is high. Read data is combinational from the address.

Top module: `wdg_lock_timer`

## Requirements
- R1: After reset the block is locked, the lock register (0x20) reads 1, the load halves and control read 0, and the reset request output is low.
- R2: Writing exactly 0xE551 to the lock register (0x20) unlocks the block, and the lock register then reads 0.
- R3: Writing any other value to the lock register locks the block again, and the lock register then reads 1.
- R4: While the block is locked, writes to load-low (0x00), load-high (0x04) and control (0x08) are ignored. Their read values do not change.
- R5: While the block is unlocked, load-low and load-high store all 16 written bits and read them back. Control stores bit 1 (run), bit 2 (new mode) and bit 3 (reset enable) and reads them back at the same positions, with all other bits reading 0.
- R6: Addresses other than 0x00, 0x04, 0x08 and 0x20 read 0, and writes to them change no register.
- R7: A 0-to-1 change of the run bit loads the counter with {load-high, load-low}. With reset enable set and a load of N, the reset request is still low just after the clock edge that takes the N-th tick, and it is high one clock later. A load of 0 raises the request one clock after the run write.
- R8: The counter decrements only on ticks taken while run is 1. Clearing run freezes it, and setting run again reloads it from the load halves.
- R9: With reset enable clear, the count reaching zero raises no reset request. Setting reset enable afterwards, while run is 1 and the count is 0, raises the request one clock after that write.
- R10: Once raised, the reset request stays high through later register writes, including clearing run and relocking. Only the block reset clears it.
- R11: Writing run as 1 while run is already 1 does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W (6) | Register byte address |
| regWdata | input | DATA_W (16) | Register write data |
| regWe | input | 1 | Write strobe, one write per cycle |
| regRdata | output | DATA_W (16) | Combinational read data |
| tickIn | input | 1 | One-cycle pulse per slow-clock period |
| sysResetReq | output | 1 | Sticky reset request on expiry |

## Verification
The bench uses the default parameters: 16-bit register halves, a 6-bit address and the key 0xE551. With these values the key check runs over the full 16 bits. A high half of 1 gives a 65538-tick countdown, which shows the borrow from the high half into the low half within the run budget. Small random load values, with random idle gaps between ticks, place the expiry edge at many different counts. Random register traffic, with random lock values and occasional correct keys, drives the lock filter through many locked and unlocked transitions.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Register byte offsets
  localparam int OFF_LOAD_LO = 'h00;
  localparam int OFF_LOAD_HI = 'h04;
  localparam int OFF_CTRL    = 'h08;
  localparam int OFF_LOCK    = 'h20;

  // Control bit positions
  localparam int BIT_RUN   = 1;
  localparam int BIT_MODE  = 2;
  localparam int BIT_RSTEN = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLo;      // store write data into low half
    logic wrHi;      // store write data into high half
    logic reload;    // copy {high, low} into counter
    logic countEn;   // tick taken while running
    logic expire;    // raise the sticky reset request
  } wdg_strobe_t;

endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter int              ADDR_W     = 6,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  input  logic              tickIn,
  input  logic [DATA_W-1:0] loadLo,
  input  logic [DATA_W-1:0] loadHi,
  input  logic              cntZero,
  output logic [DATA_W-1:0] regRdata,
  output wdg_strobe_t       strobe
);

  localparam int CTRL_W = BIT_RSTEN + 1;

  logic locked;
  logic runBit, modeBit, rstEnBit;
  logic selLo, selHi, selCtrl, selLock;
  logic wrCtrl, wrLock, keyMatch;
  logic [CTRL_W-1:0] ctrlView;

  assign selLo   = (regAddr == ADDR_W'(OFF_LOAD_LO));
  assign selHi   = (regAddr == ADDR_W'(OFF_LOAD_HI));
  assign selCtrl = (regAddr == ADDR_W'(OFF_CTRL));
  assign selLock = (regAddr == ADDR_W'(OFF_LOCK));

  assign keyMatch = (regWdata == UNLOCK_KEY);
  assign wrLock   = regWe && selLock;
  assign wrCtrl   = regWe && selCtrl && !locked;

  // Lock state: key opens, anything else closes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b1;
    end else if (wrLock) begin
      locked <= !keyMatch;
    end
  end

  // Control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      modeBit  <= 1'b0;
      rstEnBit <= 1'b0;
    end else if (wrCtrl) begin
      runBit   <= regWdata[BIT_RUN];
      modeBit  <= regWdata[BIT_MODE];
      rstEnBit <= regWdata[BIT_RSTEN];
    end
  end

  // Strobes to the datapath
  always_comb begin
    strobe.wrLo    = regWe && selLo && !locked;
    strobe.wrHi    = regWe && selHi && !locked;
    strobe.reload  = wrCtrl && regWdata[BIT_RUN] && !runBit;
    strobe.countEn = runBit && tickIn;
    strobe.expire  = runBit && rstEnBit && cntZero && !strobe.reload;
  end

  // Read mux
  always_comb begin
    ctrlView            = '0;
    ctrlView[BIT_RUN]   = runBit;
    ctrlView[BIT_MODE]  = modeBit;
    ctrlView[BIT_RSTEN] = rstEnBit;
  end

  always_comb begin
    regRdata = '0;
    if (selLo)        regRdata = loadLo;
    else if (selHi)   regRdata = loadHi;
    else if (selCtrl) regRdata = DATA_W'(ctrlView);
    else if (selLock) regRdata = DATA_W'(locked);
  end

  // R4: a blocked control write leaves the control bits alone
  assert_locked_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (locked && regWe && selCtrl) |=> $stable({runBit, modeBit, rstEnBit}));

  // R2: the key always leaves the block unlocked
  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && selLock && regWdata == UNLOCK_KEY) |=> (regRdata == regRdata) && !locked);

  // R3: a non-key lock write always locks
  assert_other_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && selLock && regWdata != UNLOCK_KEY) |=> locked);

  // R11: run already set never produces a reload
  assert_no_rerun_reload_R11: assert property (@(posedge clk) disable iff (!rstN)
    runBit |-> !strobe.reload);

endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] regWdata,
  input  wdg_strobe_t       strobe,
  output logic [DATA_W-1:0] loadLo,
  output logic [DATA_W-1:0] loadHi,
  output logic              cntZero,
  output logic              sysResetReq
);

  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] count;

  // Load halves
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadLo <= '0;
      loadHi <= '0;
    end else begin
      if (strobe.wrLo) loadLo <= regWdata;
      if (strobe.wrHi) loadHi <= regWdata;
    end
  end

  // Down counter, saturating at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.reload) begin
      count <= {loadHi, loadLo};
    end else if (strobe.countEn && !cntZero) begin
      count <= count - CNT_W'(1);
    end
  end

  assign cntZero = (count == '0);

  // Sticky reset request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysResetReq <= 1'b0;
    end else if (strobe.expire) begin
      sysResetReq <= 1'b1;
    end
  end

  // R7: reload copies the programmed halves
  assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (count == $past({loadHi, loadLo})));

  // R8: a taken tick lowers the count by exactly one
  assert_tick_decrement_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.reload && !cntZero) |=> (count == $past(count) - CNT_W'(1)));

  // R8: without a tick or reload the count holds
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.reload) |=> $stable(count));

  // R10: the request never drops while out of reset
  assert_req_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> sysResetReq);

endmodule

// File: rtl/wdg_lock_timer.sv
module wdg_lock_timer
  import wdg_pkg::*;
#(
  parameter int                DATA_W     = 16,
  parameter int                ADDR_W     = 6,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  output logic [DATA_W-1:0] regRdata,
  input  logic              tickIn,
  output logic              sysResetReq
);

  wdg_strobe_t       strobe;
  logic [DATA_W-1:0] loadLo, loadHi;
  logic              cntZero;

  wdg_ctrl #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regWe   (regWe),
    .tickIn  (tickIn),
    .loadLo  (loadLo),
    .loadHi  (loadHi),
    .cntZero (cntZero),
    .regRdata(regRdata),
    .strobe  (strobe)
  );

  wdg_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWdata   (regWdata),
    .strobe     (strobe),
    .loadLo     (loadLo),
    .loadHi     (loadHi),
    .cntZero    (cntZero),
    .sysResetReq(sysResetReq)
  );

  // R1: request is low on the first cycle after reset release
  assert_req_low_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !sysResetReq);

  // R4: blocked load writes leave both halves unchanged
  assert_locked_load_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regRdata == regRdata && !strobe.wrLo && !strobe.wrHi) |=> $stable({loadHi, loadLo}));

endmodule

// File: tb/wdg_lock_timer_tb.sv
module wdg_lock_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] KEY = 16'hE551;
  localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_CTRL = 6'h08, A_LOCK = 6'h20;
  localparam logic [15:0] C_RUN = 16'h0002, C_MODE = 16'h0004, C_RSTEN = 16'h0008;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        regWe = 1'b0;
  logic [15:0] regRdata;
  logic        tickIn = 1'b0;
  logic        sysResetReq;

  int checkCount = 0;
  int failCount  = 0;

  // Register model
  logic [15:0] mLo, mHi, mCtrl;
  logic        mLocked;

  wdg_lock_timer u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .tickIn(tickIn), .sysResetReq(sysResetReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWe = 1'b0; tickIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mLo = '0; mHi = '0; mCtrl = '0; mLocked = 1'b1;
  endtask

  // Starts and ends at a falling edge; one rising edge takes the write
  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickIn = 1'b1;
      @(negedge clk);
      tickIn = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Model update for a write, following the requirements
  function automatic void modelWrite(input logic [5:0] a, input logic [15:0] d);
    if (a == A_LOCK) mLocked = (d != KEY);
    else if (!mLocked) begin
      if (a == A_LO) mLo = d;
      else if (a == A_HI) mHi = d;
      else if (a == A_CTRL) mCtrl = d & 16'h000E;
    end
  endfunction

  function automatic logic [15:0] modelRead(input logic [5:0] a);
    if (a == A_LO) return mLo;
    if (a == A_HI) return mHi;
    if (a == A_CTRL) return mCtrl;
    if (a == A_LOCK) return {15'b0, mLocked};
    return 16'h0000;
  endfunction

  task automatic checkAllRegs(input string tag);
    logic [15:0] v;
    busRead(A_LO, v);   check(tag, v, modelRead(A_LO));
    busRead(A_HI, v);   check(tag, v, modelRead(A_HI));
    busRead(A_CTRL, v); check(tag, v, modelRead(A_CTRL));
    busRead(A_LOCK, v); check(tag, v, modelRead(A_LOCK));
    busRead(6'h10, v);  check({tag, " R6 unmapped"}, v, 16'h0);
  endtask

  // Unlock, program N, start with reset enabled; ends just after the run edge
  task automatic armTimer(input logic [15:0] lo, input logic [15:0] hi, input logic [15:0] ctl);
    busWrite(A_LOCK, KEY);
    busWrite(A_LO, lo);
    busWrite(A_HI, hi);
    busWrite(A_CTRL, ctl);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checkCount++; failCount++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int seedDummy;
    seedDummy = $urandom(32'h5EED);

    // R1 reset state
    doReset();
    checkAllRegs("R1 reset regs");
    check("R1 reset req", sysResetReq, 1'b0);

    // R4 locked writes ignored
    busWrite(A_LO, 16'h1234); modelWrite(A_LO, 16'h1234);
    busWrite(A_CTRL, C_RUN | C_RSTEN); modelWrite(A_CTRL, C_RUN | C_RSTEN);
    checkAllRegs("R4 locked");
    idle(3);
    check("R4 locked run ignored", sysResetReq, 1'b0);

    // R2 unlock, R5 readback, R3 relock
    busWrite(A_LOCK, KEY); modelWrite(A_LOCK, KEY);
    busRead(A_LOCK, v); check("R2 unlock reads 0", v, 16'h0);
    busWrite(A_LO, 16'hBEEF); modelWrite(A_LO, 16'hBEEF);
    busWrite(A_HI, 16'hA5C3); modelWrite(A_HI, 16'hA5C3);
    busWrite(A_CTRL, 16'hFFFD); modelWrite(A_CTRL, 16'hFFFD);
    checkAllRegs("R5 unlocked");
    busWrite(A_LOCK, ~KEY); modelWrite(A_LOCK, ~KEY);
    busRead(A_LOCK, v); check("R3 relock reads 1", v, 16'h1);
    busWrite(A_HI, 16'h0000); modelWrite(A_HI, 16'h0000);
    checkAllRegs("R4 after relock");

    // Random register traffic, run bit always clear
    for (int i = 0; i < 150; i++) begin
      logic [5:0]  a;
      logic [15:0] d;
      int sel;
      sel = $urandom % 6;
      d = 16'($urandom);
      case (sel)
        0: a = A_LO;
        1: a = A_HI;
        2: begin a = A_CTRL; d = d & ~C_RUN; end
        3: begin a = A_LOCK; if ($urandom % 2) d = KEY; end
        4: a = (($urandom % 2) != 0) ? 6'h10 : 6'h0C;
        default: begin a = A_LOCK; d = KEY; end
      endcase
      busWrite(a, d);
      modelWrite(a, d);
      checkAllRegs("R4/R5/R6 random");
    end
    check("R6 no spurious req", sysResetReq, 1'b0);

    // R7 directed: small load and zero load
    doReset();
    armTimer(16'd5, 16'd0, C_RUN | C_RSTEN);
    ticks(4); check("R7 before expiry", sysResetReq, 1'b0);
    ticks(1); check("R7 at Nth tick", sysResetReq, 1'b0);
    idle(1);  check("R7 one clock later", sysResetReq, 1'b1);

    doReset();
    armTimer(16'd0, 16'd0, C_RUN | C_RSTEN);
    check("R7 zero load run edge", sysResetReq, 1'b0);
    idle(1); check("R7 zero load", sysResetReq, 1'b1);

    // R7 random loads with random idle gaps
    for (int t = 0; t < 10; t++) begin
      int n;
      n = 1 + ($urandom % 30);
      doReset();
      armTimer(16'(n), 16'd0, C_RUN | C_RSTEN | ((($urandom % 2) != 0) ? C_MODE : 16'h0));
      for (int k = 0; k < n; k++) begin
        idle($urandom % 3);
        check("R7 random before expiry", sysResetReq, 1'b0);
        ticks(1);
      end
      check("R7 random at Nth tick", sysResetReq, 1'b0);
      idle(1);
      check("R7 random expiry", sysResetReq, 1'b1);
    end

    // R7 high half: 0x0001_0002 ticks
    doReset();
    armTimer(16'd2, 16'd1, C_RUN | C_RSTEN);
    ticks(65537); check("R7 high half before", sysResetReq, 1'b0);
    ticks(1);     check("R7 high half at N", sysResetReq, 1'b0);
    idle(1);      check("R7 high half expiry", sysResetReq, 1'b1);

    // R8 freeze while stopped, reload on restart
    doReset();
    armTimer(16'd10, 16'd0, C_RUN | C_RSTEN);
    ticks(4);
    busWrite(A_CTRL, C_RSTEN);
    ticks(20); check("R8 frozen", sysResetReq, 1'b0);
    busWrite(A_CTRL, C_RUN | C_RSTEN);
    ticks(9);  check("R8 reloaded not yet", sysResetReq, 1'b0);
    ticks(1); idle(1); check("R8 reload expiry", sysResetReq, 1'b1);

    // R11 rewriting run does not reload
    doReset();
    armTimer(16'd8, 16'd0, C_RUN | C_RSTEN);
    ticks(5);
    busWrite(A_CTRL, C_RUN | C_RSTEN);
    ticks(3); check("R11 no reload at N", sysResetReq, 1'b0);
    idle(1);  check("R11 expiry on original count", sysResetReq, 1'b1);

    // R9 no request without enable; late enable fires
    doReset();
    armTimer(16'd3, 16'd0, C_RUN);
    ticks(10); idle(5); check("R9 no enable", sysResetReq, 1'b0);
    busWrite(A_CTRL, C_RUN | C_RSTEN);
    check("R9 late enable write edge", sysResetReq, 1'b0);
    idle(1); check("R9 late enable", sysResetReq, 1'b1);

    // R10 sticky through writes
    busWrite(A_CTRL, 16'h0000);
    busWrite(A_LOCK, ~KEY);
    busWrite(A_LO, 16'hFFFF);
    idle(4); check("R10 sticky", sysResetReq, 1'b1);
    doReset();
    check("R10 cleared by reset", sysResetReq, 1'b0);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule